// File: doc/BRIEF.md
# Variable-Window Running Average Filter

This block smooths a stream of signed fixed-point samples by averaging the most recent W samples, where W can be set at run time. Each channel keeps a running sum. On every accepted sample the new value is added to the sum, and the value that entered exactly W samples earlier is subtracted. That older value is read back from a circular RAM delay line. The delay line is sized at build time for the largest window allowed.

The sum is scaled to an average without a divider. In the default build it is multiplied by an unsigned reciprocal held in a register that the host writes. The reciprocal has 16 fraction bits (value/65536). A build-time option replaces the multiply with an arithmetic right shift by log2(W), for power-of-two windows. Two channels share one sample strobe and one window setting, but each has its own sum and its own delay storage.

The output strobe stays low after reset, and after any window change, until W samples have been accepted. A window write empties the filter.

Top module: `run_avg_filter`

## Requirements
- R1: After reset, out_valid and out_data are 0, the window is 4 and the reciprocal is 16384 (0.25).
- R2: For each accepted sample, each channel's output is floor(S * recip / 65536), where S is the sum of that channel's last W accepted samples and recip is the current reciprocal register value.
- R3: A window write loads win_len. A value of 0 is taken as 1, and a value above MAX_WIN (64) is taken as MAX_WIN.
- R4: A window write clears the sum and the fill count. A sample strobed in the same cycle as the write is discarded.
- R5: out_valid is a one-cycle pulse, registered on the same edge that accepts the sample. It is high only once at least W samples have been accepted since reset or since the last window write.
- R6: A reciprocal write changes the scaling of later outputs without clearing the sum or dropping out_valid.
- R7: A scaled result above 32767 is saturated to 32767, and one below -32768 is saturated to -32768.
- R8: Channel c uses in_data[16c+15:16c] and drives out_data[16c+15:16c]. The channels do not affect each other.
- R9: With POW2 set, the output is the sum arithmetically shifted right by log2(W), saturated, and the reciprocal is ignored.
- R10: While no sample is accepted, out_valid is low and out_data keeps its last value.
- R11: The delay is exact at the boundary windows W=1 and W=MAX_WIN, including under back-to-back samples and delay-line wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe for all channels |
| in_data | input | NCH*DATA_W | Signed samples, channel c at bits [16c+15:16c] |
| win_we | input | 1 | Window length write strobe |
| win_len | input | $clog2(MAX_WIN+1) | New window length |
| recip_we | input | 1 | Reciprocal write strobe |
| recip_val | input | RECIP_W | Unsigned reciprocal, 16 fraction bits |
| out_valid | output | 1 | Averaged output strobe |
| out_data | output | NCH*DATA_W | Signed averages, channel c at bits [16c+15:16c] |

## Verification
The average and its strobe come from registers that load on the same rising edge that accepts the sample. Both are therefore due one edge after the strobe is driven. The bench drives inputs on falling edges and reads results on the next falling edge, half a period after the loading edge. In bursts, it checks the previous sample's result in the same falling-edge slot where it drives the next sample.

Window and reciprocal writes take effect at the edge that samples them. The bench model clears its history for a window write at that same point, then counts W fresh samples before it expects the strobe.

// File: rtl/raf_pkg.sv
package raf_pkg;

  typedef logic signed [63:0] wide_t;

  // clamp a wide signed value into a signed field of w bits
  function automatic wide_t sat_wide(input wide_t v, input int w);
    wide_t hi;
    wide_t lo;
    hi = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
    lo = -hi - wide_t'(1);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // sum times unsigned reciprocal, floor-shifted by the fraction width
  function automatic wide_t mul_scale(input wide_t s, input logic [31:0] r, input int frac);
    wide_t p;
    p = s * $signed({32'b0, r});
    return p >>> frac;
  endfunction

  function automatic wide_t shift_scale(input wide_t s, input int sh);
    return s >>> sh;
  endfunction

  function automatic int floor_log2(input logic [31:0] v);
    int r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/raf_ctrl.sv
module raf_ctrl #(
  parameter int MAX_WIN   = 64,
  parameter int RST_WIN   = 4,
  parameter int RECIP_W   = 18,
  parameter int RST_RECIP = 16384,
  localparam int WL_W     = $clog2(MAX_WIN + 1),
  localparam int AW       = $clog2(MAX_WIN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               win_we,
  input  logic [WL_W-1:0]    win_len,
  input  logic               recip_we,
  input  logic [RECIP_W-1:0] recip_val,
  output logic               take,
  output logic               clr,
  output logic               sub_en,
  output logic [AW-1:0]      wp,
  output logic [AW-1:0]      rp,
  output logic [RECIP_W-1:0] recip_q,
  output logic [5:0]         shamt,
  output logic               out_valid,
  output logic [WL_W-1:0]    fill_q,
  output logic [WL_W-1:0]    win_q
);
  import raf_pkg::*;

  function automatic logic [WL_W-1:0] clamp_win(input logic [WL_W-1:0] v);
    if (v == '0) return WL_W'(1);
    if (int'(v) > MAX_WIN) return WL_W'(MAX_WIN);
    return v;
  endfunction

  logic full_next;

  assign clr    = win_we;
  assign take   = in_valid & ~win_we;
  // the leaving sample exists once W samples sit in the line
  assign sub_en = (fill_q == win_q);
  // read before write in one cycle: offset W gives a delay of exactly W
  assign rp     = wp - win_q[AW-1:0];
  assign shamt  = 6'(floor_log2(32'(win_q)));
  assign full_next = ({1'b0, fill_q} + (WL_W+1)'(1)) >= {1'b0, win_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q     <= WL_W'(RST_WIN);
      fill_q    <= '0;
      wp        <= '0;
      recip_q   <= RECIP_W'(RST_RECIP);
      out_valid <= 1'b0;
    end else begin
      out_valid <= take && full_next;
      if (recip_we) recip_q <= recip_val;
      if (clr) begin
        win_q  <= clamp_win(win_len);
        fill_q <= '0;
      end else if (take && (fill_q != win_q)) begin
        fill_q <= fill_q + WL_W'(1);
      end
      if (take) wp <= wp + AW'(1);
    end
  end

endmodule

// File: rtl/raf_lane.sv
module raf_lane #(
  parameter int DATA_W     = 16,
  parameter int ACC_W      = 22,
  parameter int AW         = 6,
  parameter int RECIP_W    = 18,
  parameter int RECIP_FRAC = 16,
  parameter bit POW2       = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     take,
  input  logic                     sub_en,
  input  logic [AW-1:0]            wp,
  input  logic [AW-1:0]            rp,
  input  logic [RECIP_W-1:0]       recip,
  input  logic [5:0]               shamt,
  input  logic signed [DATA_W-1:0] x,
  output logic signed [DATA_W-1:0] y
);
  import raf_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic signed [DATA_W-1:0] mem [DEPTH];
  logic signed [ACC_W-1:0]  sum_q;
  logic signed [ACC_W-1:0]  sum_n;
  logic signed [ACC_W-1:0]  leave;

  function automatic logic signed [DATA_W-1:0] scale_avg(input logic signed [ACC_W-1:0] s);
    wide_t w;
    wide_t r;
    w = 64'(s);
    if (POW2) r = shift_scale(w, int'(shamt));
    else      r = mul_scale(w, 32'(recip), RECIP_FRAC);
    return DATA_W'(sat_wide(r, DATA_W));
  endfunction

  assign leave = sub_en ? ACC_W'(mem[rp]) : '0;
  assign sum_n = sum_q + ACC_W'(x) - leave;

  always_ff @(posedge clk) begin
    if (take) mem[wp] <= x;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= '0;
      y     <= '0;
    end else if (clr) begin
      sum_q <= '0;
    end else if (take) begin
      sum_q <= sum_n;
      y     <= scale_avg(sum_n);
    end
  end

endmodule

// File: rtl/run_avg_filter.sv
module run_avg_filter #(
  parameter int NCH        = 2,
  parameter int DATA_W     = 16,
  parameter int MAX_WIN    = 64,
  parameter int RECIP_W    = 18,
  parameter int RECIP_FRAC = 16,
  parameter int RST_WIN    = 4,
  parameter int RST_RECIP  = 16384,
  parameter bit POW2       = 1'b0,
  localparam int WL_W      = $clog2(MAX_WIN + 1),
  localparam int AW        = $clog2(MAX_WIN),
  localparam int ACC_W     = DATA_W + $clog2(MAX_WIN)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [NCH*DATA_W-1:0] in_data,
  input  logic                  win_we,
  input  logic [WL_W-1:0]       win_len,
  input  logic                  recip_we,
  input  logic [RECIP_W-1:0]    recip_val,
  output logic                  out_valid,
  output logic [NCH*DATA_W-1:0] out_data
);

  logic               take;
  logic               clr;
  logic               sub_en;
  logic [AW-1:0]      wp;
  logic [AW-1:0]      rp;
  logic [RECIP_W-1:0] recip_q;
  logic [5:0]         shamt;
  logic [WL_W-1:0]    fill_q;
  logic [WL_W-1:0]    win_q;

  raf_ctrl #(
    .MAX_WIN(MAX_WIN), .RST_WIN(RST_WIN),
    .RECIP_W(RECIP_W), .RST_RECIP(RST_RECIP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .win_we(win_we), .win_len(win_len),
    .recip_we(recip_we), .recip_val(recip_val),
    .take(take), .clr(clr), .sub_en(sub_en),
    .wp(wp), .rp(rp), .recip_q(recip_q), .shamt(shamt),
    .out_valid(out_valid), .fill_q(fill_q), .win_q(win_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    raf_lane #(
      .DATA_W(DATA_W), .ACC_W(ACC_W), .AW(AW),
      .RECIP_W(RECIP_W), .RECIP_FRAC(RECIP_FRAC), .POW2(POW2)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .clr(clr), .take(take),
      .sub_en(sub_en), .wp(wp), .rp(rp), .recip(recip_q),
      .shamt(shamt),
      .x(in_data[c*DATA_W +: DATA_W]),
      .y(out_data[c*DATA_W +: DATA_W])
    );
  end

endmodule

// File: rtl/raf_chk.sv
module raf_chk #(
  parameter int WL_W    = 7,
  parameter int MAX_WIN = 64,
  parameter int NCH     = 2,
  parameter int DATA_W  = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  take,
  input logic                  clr,
  input logic [WL_W-1:0]       fill_q,
  input logic [WL_W-1:0]       win_q,
  input logic                  out_valid,
  input logic [NCH*DATA_W-1:0] out_data
);

  // R5
  valid_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(take));

  // R4
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fill_q == '0 && !out_valid));

  // R3
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != '0) && (int'(win_q) <= MAX_WIN));

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= win_q);

  // R5
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fill_q != win_q) |=> fill_q == $past(fill_q) + WL_W'(1));

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(out_data) && !out_valid));

endmodule

bind run_avg_filter raf_chk #(
  .WL_W(WL_W), .MAX_WIN(MAX_WIN), .NCH(NCH), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .clr(clr),
  .fill_q(fill_q), .win_q(win_q),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_run_avg_filter.sv
`timescale 1ns/1ps
module sim_run_avg_filter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        win_we;
  logic [6:0]  win_len;
  logic        recip_we;
  logic [17:0] recip_val;
  logic        out_valid0, out_valid1;
  logic [31:0] out_data0, out_data1;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  int     W;
  longint recip;
  int     cnt;
  int     h [2][4096];

  always #2 clk = ~clk;

  run_avg_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .win_we(win_we), .win_len(win_len), .recip_we(recip_we),
    .recip_val(recip_val), .out_valid(out_valid0), .out_data(out_data0)
  );

  run_avg_filter #(.POW2(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .win_we(win_we), .win_len(win_len), .recip_we(recip_we),
    .recip_val(recip_val), .out_valid(out_valid1), .out_data(out_data1)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint model_avg(int ch, bit p2);
    longint s;
    longint v;
    s = 0;
    for (int k = cnt - W; k < cnt; k++) s += longint'(h[ch][k]);
    if (p2) v = s >>> $clog2(W);
    else    v = (s * recip) >>> 16;
    if (v > 32767)  v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  function automatic bit is_pow2(int v);
    return (v & (v - 1)) == 0;
  endfunction

  task automatic check_now(string req);
    longint a;
    if (cnt >= W) begin
      chk(out_valid0 == 1'b1, req, longint'(out_valid0), 1);
      for (int ch = 0; ch < 2; ch++) begin
        a = longint'($signed(out_data0[ch*16 +: 16]));
        chk(a == model_avg(ch, 0), req, a, model_avg(ch, 0));
        if (is_pow2(W)) begin
          a = longint'($signed(out_data1[ch*16 +: 16]));
          chk(a == model_avg(ch, 1), "R9", a, model_avg(ch, 1));
        end
      end
    end else begin
      chk(out_valid0 == 1'b0, req, longint'(out_valid0), 0);
    end
  endtask

  task automatic drive(int a, int b);
    in_valid = 1'b1;
    in_data  = {16'(b), 16'(a)};
    h[0][cnt] = a;
    h[1][cnt] = b;
    cnt++;
  endtask

  task automatic send(int a, int b, string req);
    @(negedge clk);
    drive(a, b);
    @(negedge clk);
    in_valid = 1'b0;
    check_now(req);
  endtask

  task automatic burst(int n, int mul, int off, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) check_now(req);
      drive(((i * mul) % 2001) - 1000 + off, 700 - ((i * (mul + 3)) % 1401));
    end
    @(negedge clk);
    in_valid = 1'b0;
    check_now(req);
  endtask

  task automatic set_win(int v);
    @(negedge clk);
    win_we  = 1'b1;
    win_len = 7'(v);
    @(negedge clk);
    win_we  = 1'b0;
    W   = (v == 0) ? 1 : ((v > 64) ? 64 : v);
    cnt = 0;
  endtask

  task automatic set_recip(int v);
    @(negedge clk);
    recip_we  = 1'b1;
    recip_val = 18'(v);
    @(negedge clk);
    recip_we  = 1'b0;
    recip = longint'(v);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; win_we = 1'b0;
    win_len = '0; recip_we = 1'b0; recip_val = '0;
    W = 4; recip = 16384; cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid0 == 1'b0, "R1", longint'(out_valid0), 0);
    chk(out_data0 == '0, "R1", longint'(out_data0), 0);
    chk(out_data1 == '0, "R1", longint'(out_data1), 0);
    // defaults: window 4, reciprocal 0.25
    send(100, -8, "R1");
    send(200, -16, "R1");
    send(300, -24, "R1");
    send(400, -33, "R1");
  endtask

  task automatic t_stream();
    send(1000, 5, "R2");
    send(-3000, 7, "R2");
    send(17, -901, "R2");
    send(-1, -1, "R2");
  endtask

  task automatic t_hold();
    logic [31:0] last;
    last = out_data0;
    repeat (3) @(negedge clk);
    chk(out_valid0 == 1'b0, "R10", longint'(out_valid0), 0);
    chk(out_data0 == last, "R10", longint'(out_data0), longint'(last));
  endtask

  task automatic t_window();
    set_win(5);
    set_recip(13107);
    for (int i = 0; i < 7; i++) send(i * 111 - 300, 250 - i * 40, "R4");
    set_win(0);
    send(-1234, 4321, "R3");
    send(77, -77, "R3");
    set_win(100);
    set_recip(1024);
    for (int i = 0; i < 63; i++) send(i, -i, "R3");
    send(9, 9, "R3");
  endtask

  task automatic t_same_cycle();
    set_win(3);
    set_recip(21845);
    send(500, 500, "R4");
    send(600, 600, "R4");
    @(negedge clk);
    win_we = 1'b1; win_len = 7'd2; in_valid = 1'b1; in_data = {16'd30000, 16'd30000};
    @(negedge clk);
    win_we = 1'b0; in_valid = 1'b0;
    W = 2; cnt = 0;
    chk(out_valid0 == 1'b0, "R4", longint'(out_valid0), 0);
    set_recip(32768);
    send(10, 20, "R4");
    send(30, 40, "R4");
  endtask

  task automatic t_recip();
    set_win(5);
    set_recip(13107);
    for (int i = 0; i < 5; i++) send(1000 + i, -2000 + i, "R6");
    set_recip(26214);
    send(1500, -1500, "R6");
  endtask

  task automatic t_sat();
    set_win(4);
    set_recip(65536);
    for (int i = 0; i < 5; i++) send(20000, -20000, "R7");
  endtask

  task automatic t_chan();
    set_win(2);
    set_recip(32768);
    send(32767, -32768, "R8");
    send(32767, -32768, "R8");
    send(-5, 12345, "R8");
  endtask

  task automatic t_bounds();
    set_win(64);
    set_recip(1024);
    burst(150, 37, 0, "R11");
    set_win(1);
    set_recip(65536);
    burst(6, 113, 5, "R11");
    set_win(8);
    set_recip(8192);
    burst(20, 59, -3, "R9");
  endtask

  initial begin
    t_reset();
    t_stream();
    t_hold();
    t_window();
    t_same_cycle();
    t_recip();
    t_sat();
    t_chan();
    t_bounds();
    t_hold();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule